// File: doc/BRIEF.md
# Flagged Byte Stream Hit Record Assembler

This block rebuilds fixed-format detector hit records from a stream of bytes. Each byte carries a two-bit frame code in its two low bits and six bits of payload above them. The frame code marks the byte as the start of a packet, a continuation, the end of a packet, or filler. The block gathers the payload bits of a packet, most significant chunk first, into 96-bit records. Each record is four 24-bit signed fixed-point values: x, y and z position and drift radius. Each value has 8 integer bits, including the sign, and 16 fraction bits, in tenths of a metre.

Sixteen payload chunks make one record. A packet can carry several records back to back. The packet must close on a byte that also completes a record. The block reports two kinds of malformed stream. A record that is cut short raises a one-cycle truncation pulse. Data that arrives outside any packet raises an error flag that stays set until reset. The block sits between an input byte FIFO and a record consumer, and it has no backpressure.

Top module: `hit_record_assembler`

## Requirements
- R1: A byte is taken on a rising clock edge when in_valid is high. Bits [1:0] are the frame code: 2'b01 starts a packet, 2'b00 continues it, 2'b10 ends it, and 2'b11 is filler. Bits [7:2] are payload. The first payload chunk of a record lands in rec_data[95:90] and the sixteenth in rec_data[5:0]. rec_valid is high for exactly the one cycle after the edge that takes the sixteenth chunk.
- R2: rec_data holds x in [95:72], y in [71:48], z in [47:24] and drift radius in [23:0]. Each is 24-bit two's complement with 16 fraction bits.
- R3: A continuation byte that completes a record emits that record. The packet stays open, and the next continuation byte starts the next record.
- R4: An end byte that brings the sixteenth chunk emits the record and closes the packet.
- R5: A continuation or end byte that arrives while no packet is open is dropped. It sets orphan_err, which stays high until reset.
- R6: A start byte that arrives in the middle of a record drops the partial record and raises trunc_err for one cycle. The start byte's payload then becomes chunk one of a new record. A start byte that arrives between records raises no error.
- R7: Filler bytes, and cycles with in_valid low, change neither the assembly state nor any output.
- R8: An end byte that arrives before chunk sixteen drops the partial record and raises trunc_err for one cycle without rec_valid. It also closes the packet.
- R9: rec_data keeps the last emitted record until the next rec_valid.
- R10: While rst is high (synchronous), rec_valid, trunc_err and orphan_err go low and rec_data clears to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte present this cycle |
| in_byte | input | 8 | Payload in [7:2], frame code in [1:0] |
| rec_valid | output | 1 | One-cycle strobe for a new record |
| rec_data | output | 96 | Last assembled record |
| trunc_err | output | 1 | One-cycle pulse when a partial record is dropped |
| orphan_err | output | 1 | Sticky flag for data seen outside a packet |

## Verification
A wrong chunk count inside the block shows up when the record strobe is due. The strobe comes one byte early or late, and the record is misaligned by six bits at the very next record boundary. A wrong open-packet state shows at the next continuation or end byte, which either fails to raise the sticky orphan flag or raises it by mistake. Wrong filler handling appears as a shifted record or a stray pulse on the byte that follows. The tests put each of these bytes right next to a record boundary so that a fault shows within one record.

// File: rtl/hra_pkg.sv
package hra_pkg;
   typedef enum logic [1:0] {
      FLG_BODY = 2'b00,
      FLG_HEAD = 2'b01,
      FLG_TAIL = 2'b10,
      FLG_SKIP = 2'b11
   } flag_e;
endpackage

// File: rtl/hra_flag_decode.sv
module hra_flag_decode
   import hra_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int FLAG_W = 2,
   localparam int PAY_W = BYTE_W - FLAG_W
) (
   input  logic [BYTE_W-1:0] byte_i,
   output flag_e             flag_o,
   output logic [PAY_W-1:0]  payload_o
);
   // frame code in the low bits, payload above it
   assign flag_o    = flag_e'(byte_i[FLAG_W-1:0]);
   assign payload_o = byte_i[BYTE_W-1:FLAG_W];
endmodule

// File: rtl/hra_frame_ctrl.sv
module hra_frame_ctrl
   import hra_pkg::*;
#(
   parameter int BYTES_PER_REC = 16,
   localparam int CNT_W = (BYTES_PER_REC > 2) ? $clog2(BYTES_PER_REC) : 1
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  in_valid,
   input  flag_e flag,
   output logic  load_o,
   output logic  shift_o,
   output logic  emit_o,
   output logic  trunc_o,
   output logic  orphan_o
);
   logic             in_pkt, pkt_n;
   logic [CNT_W-1:0] cnt, cnt_n;
   logic             trunc_n, orphan_set, last;

   assign last = (cnt == CNT_W'(BYTES_PER_REC - 1));

   always_comb begin
      load_o     = 1'b0;
      shift_o    = 1'b0;
      emit_o     = 1'b0;
      trunc_n    = 1'b0;
      orphan_set = 1'b0;
      pkt_n      = in_pkt;
      cnt_n      = cnt;
      if (in_valid) begin
         unique case (flag)
            FLG_HEAD: begin
               load_o  = 1'b1;
               trunc_n = in_pkt && (cnt != '0);
               pkt_n   = 1'b1;
               cnt_n   = CNT_W'(1);
            end
            FLG_BODY: begin
               if (!in_pkt) begin
                  orphan_set = 1'b1;
               end else begin
                  shift_o = 1'b1;
                  if (last) begin
                     emit_o = 1'b1;
                     cnt_n  = '0;
                  end else begin
                     cnt_n = cnt + CNT_W'(1);
                  end
               end
            end
            FLG_TAIL: begin
               if (!in_pkt) begin
                  orphan_set = 1'b1;
               end else begin
                  pkt_n = 1'b0;
                  cnt_n = '0;
                  if (last) begin
                     shift_o = 1'b1;
                     emit_o  = 1'b1;
                  end else begin
                     trunc_n = 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         in_pkt   <= 1'b0;
         cnt      <= '0;
         trunc_o  <= 1'b0;
         orphan_o <= 1'b0;
      end else begin
         in_pkt   <= pkt_n;
         cnt      <= cnt_n;
         trunc_o  <= trunc_n;
         orphan_o <= orphan_o | orphan_set;
      end
   end
endmodule

// File: rtl/hra_record_store.sv
module hra_record_store #(
   parameter int PAY_W = 6,
   parameter int REC_W = 96
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             shift,
   input  logic             emit,
   input  logic [PAY_W-1:0] payload,
   output logic             rec_valid_o,
   output logic [REC_W-1:0] rec_data_o
);
   logic [REC_W-1:0] acc;
   logic [REC_W-1:0] acc_next;

   assign acc_next = {acc[REC_W-PAY_W-1:0], payload};

   always_ff @(posedge clk) begin
      if (rst) begin
         acc         <= '0;
         rec_data_o  <= '0;
         rec_valid_o <= 1'b0;
      end else begin
         rec_valid_o <= emit;
         if (load) begin
            acc <= {{(REC_W-PAY_W){1'b0}}, payload};
         end else if (shift) begin
            acc <= acc_next;
         end
         if (emit) begin
            rec_data_o <= acc_next;
         end
      end
   end
endmodule

// File: rtl/hit_record_assembler.sv
module hit_record_assembler
   import hra_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int FLAG_W     = 2,
   parameter int FIELD_W    = 24,
   parameter int NUM_FIELDS = 4
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          in_valid,
   input  logic [BYTE_W-1:0]             in_byte,
   output logic                          rec_valid,
   output logic [FIELD_W*NUM_FIELDS-1:0] rec_data,
   output logic                          trunc_err,
   output logic                          orphan_err
);
   localparam int REC_W         = FIELD_W * NUM_FIELDS;
   localparam int PAY_W         = BYTE_W - FLAG_W;
   localparam int BYTES_PER_REC = REC_W / PAY_W;

   generate
      if (FLAG_W != 2) begin : g_bad_flag
         $error("frame code must be two bits");
      end
      if (PAY_W < 1) begin : g_bad_pay
         $error("byte has no payload bits");
      end else if (REC_W % PAY_W != 0) begin : g_bad_fit
         $error("record width must be a multiple of payload width");
      end else if (BYTES_PER_REC < 2) begin : g_bad_len
         $error("record must span at least two bytes");
      end
   endgenerate

   flag_e            flag;
   logic [PAY_W-1:0] payload;
   logic             load, shift, emit;

   hra_flag_decode #(.BYTE_W(BYTE_W), .FLAG_W(FLAG_W)) u_dec (
      .byte_i    (in_byte),
      .flag_o    (flag),
      .payload_o (payload)
   );

   hra_frame_ctrl #(.BYTES_PER_REC(BYTES_PER_REC)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .flag     (flag),
      .load_o   (load),
      .shift_o  (shift),
      .emit_o   (emit),
      .trunc_o  (trunc_err),
      .orphan_o (orphan_err)
   );

   hra_record_store #(.PAY_W(PAY_W), .REC_W(REC_W)) u_store (
      .clk         (clk),
      .rst         (rst),
      .load        (load),
      .shift       (shift),
      .emit        (emit),
      .payload     (payload),
      .rec_valid_o (rec_valid),
      .rec_data_o  (rec_data)
   );
endmodule

// File: rtl/hit_record_assembler_chk.sv
module hit_record_assembler_chk #(
   parameter int BYTE_W = 8,
   parameter int REC_W  = 96
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [BYTE_W-1:0] in_byte,
   input logic              rec_valid,
   input logic [REC_W-1:0]  rec_data,
   input logic              trunc_err,
   input logic              orphan_err
);
   assert_emit_source_R1: assert property (@(posedge clk) disable iff (rst)
      rec_valid |-> ($past(in_valid) && !$past(in_byte[0])));

   assert_orphan_sticky_R5: assert property (@(posedge clk) disable iff (rst)
      orphan_err |=> orphan_err);

   assert_orphan_cause_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(orphan_err) |-> ($past(in_valid) && !$past(in_byte[0])));

   assert_trunc_cause_R6: assert property (@(posedge clk) disable iff (rst)
      trunc_err |-> ($past(in_valid) && ($past(in_byte[1]) != $past(in_byte[0]))));

   assert_filler_quiet_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_byte[1:0] == 2'b11) |=> (!rec_valid && !trunc_err && $stable(rec_data)));

   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!rec_valid && !trunc_err));

   assert_no_emit_on_drop_R8: assert property (@(posedge clk) disable iff (rst)
      !(trunc_err && rec_valid));

   assert_data_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !rec_valid |-> $stable(rec_data));
endmodule

bind hit_record_assembler hit_record_assembler_chk #(
   .BYTE_W(BYTE_W), .REC_W(FIELD_W*NUM_FIELDS)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .in_byte    (in_byte),
   .rec_valid  (rec_valid),
   .rec_data   (rec_data),
   .trunc_err  (trunc_err),
   .orphan_err (orphan_err)
);

// File: tb/hit_record_assembler_bench.sv
module hit_record_assembler_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        rec_valid;
   logic [95:0] rec_data;
   logic        trunc_err;
   logic        orphan_err;

   int   errors = 0;
   int   checks = 0;
   bit   done = 1'b0;
   logic last_valid, last_trunc;

   always #10 clk = ~clk;

   hit_record_assembler u_hit_record_assembler (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
      .rec_valid(rec_valid), .rec_data(rec_data),
      .trunc_err(trunc_err), .orphan_err(orphan_err)
   );

   task automatic check_eq(string req, string what, logic [95:0] act, logic [95:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic send_byte(logic [1:0] flg, logic [5:0] pl);
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = {pl, flg};
      @(posedge clk);
      #1;
      last_valid = rec_valid;
      last_trunc = trunc_err;
   endtask

   task automatic idle_cycle();
      @(negedge clk);
      in_valid = 1'b0;
      in_byte  = 8'h00;
      @(posedge clk);
      #1;
      last_valid = rec_valid;
      last_trunc = trunc_err;
   endtask

   function automatic logic [95:0] mk(logic [23:0] x, logic [23:0] y,
                                      logic [23:0] z, logic [23:0] d);
      return {x, y, z, d};
   endfunction

   task automatic send_rec(logic [95:0] rec, bit head, bit tail, bit exp_trunc0, string req);
      for (int i = 0; i < 16; i++) begin
         logic [1:0] f;
         f = (i == 0 && head) ? 2'b01 : ((i == 15 && tail) ? 2'b10 : 2'b00);
         send_byte(f, rec[95-6*i -: 6]);
         if (i == 0) check_eq(req, "trunc on first byte", 96'(last_trunc), 96'(exp_trunc0));
         if (i < 15) begin
            if (last_valid) check_eq(req, "early rec_valid", 96'(last_valid), 96'd0);
         end else begin
            check_eq(req, "rec_valid on chunk 16", 96'(last_valid), 96'd1);
            check_eq(req, "rec_data", rec_data, rec);
            check_eq(req, "no trunc at completion", 96'(last_trunc), 96'd0);
         end
      end
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      check_eq("R10", "rec_valid after reset", 96'(rec_valid), 96'd0);
      check_eq("R10", "trunc_err after reset", 96'(trunc_err), 96'd0);
      check_eq("R10", "orphan_err after reset", 96'(orphan_err), 96'd0);
      check_eq("R10", "rec_data after reset", rec_data, 96'd0);
   endtask

   task automatic t_single();
      logic [95:0] r;
      r = mk(24'h01A8F5, 24'hFFF334, 24'h020000, 24'h000669);
      send_rec(r, 1, 1, 0, "R1");
      check_eq("R2", "x field", 96'(rec_data[95:72]), 96'h01A8F5);
      check_eq("R2", "y field", 96'(rec_data[71:48]), 96'hFFF334);
      check_eq("R2", "z field", 96'(rec_data[47:24]), 96'h020000);
      check_eq("R2", "drift field", 96'(rec_data[23:0]), 96'h000669);
      idle_cycle();
      check_eq("R1", "strobe lasts one cycle", 96'(last_valid), 96'd0);
      repeat (3) idle_cycle();
      check_eq("R9", "data held while idle", rec_data, r);
   endtask

   task automatic t_multi();
      logic [95:0] a, b;
      a = mk(24'h123456, 24'h89ABCD, 24'hFEDCBA, 24'h0F0F0F);
      b = mk(24'hA5A5A5, 24'h5A5A5A, 24'h3C3C3C, 24'hC3C3C3);
      send_rec(a, 1, 0, 0, "R3");
      send_rec(b, 0, 1, 0, "R4");
      check_eq("R4", "orphan before extra byte", 96'(orphan_err), 96'd0);
      send_byte(2'b00, 6'h15);
      check_eq("R4", "packet closed: extra body is orphan", 96'(orphan_err), 96'd1);
      check_eq("R5", "orphan byte not emitted", 96'(last_valid), 96'd0);
      do_reset();
   endtask

   task automatic t_orphan();
      logic [95:0] r;
      r = mk(24'h7FFFFF, 24'h800000, 24'h000001, 24'hFFFFFF);
      send_byte(2'b10, 6'h3F);
      check_eq("R5", "orphan tail sets flag", 96'(orphan_err), 96'd1);
      check_eq("R5", "orphan tail no trunc", 96'(last_trunc), 96'd0);
      send_byte(2'b00, 6'h01);
      check_eq("R5", "flag still set", 96'(orphan_err), 96'd1);
      send_rec(r, 1, 1, 0, "R5");
      repeat (2) idle_cycle();
      check_eq("R5", "flag sticky after good packet", 96'(orphan_err), 96'd1);
      do_reset();
   endtask

   task automatic t_head_abort();
      logic [95:0] b, c, d;
      b = mk(24'h111111, 24'h222222, 24'h333333, 24'h444444);
      c = mk(24'h0ABCDE, 24'hF01234, 24'h00FF00, 24'h123123);
      d = mk(24'hDEAD01, 24'hBEEF02, 24'hCAFE03, 24'hF00D04);
      send_byte(2'b01, 6'h2A);
      for (int i = 0; i < 5; i++) send_byte(2'b00, 6'(i + 7));
      send_rec(b, 1, 1, 1, "R6");
      send_rec(c, 1, 0, 0, "R6");
      send_rec(d, 1, 1, 0, "R6");
      idle_cycle();
      check_eq("R6", "trunc is a single pulse", 96'(last_trunc), 96'd0);
      check_eq("R6", "no orphan from restart", 96'(orphan_err), 96'd0);
   endtask

   task automatic t_filler();
      logic [95:0] r;
      r = mk(24'h0C0FFE, 24'hFFFF00, 24'h00ABCD, 24'h765432);
      for (int i = 0; i < 16; i++) begin
         logic [1:0] f;
         f = (i == 0) ? 2'b01 : ((i == 15) ? 2'b10 : 2'b00);
         send_byte(f, r[95-6*i -: 6]);
         if (i == 15) begin
            check_eq("R7", "rec_valid with gaps", 96'(last_valid), 96'd1);
            check_eq("R7", "rec_data with gaps", rec_data, r);
         end else begin
            send_byte(2'b11, 6'(i * 5));
            if (last_valid || last_trunc)
               check_eq("R7", "filler caused output", 96'({last_valid, last_trunc}), 96'd0);
            if (i % 3 == 0) idle_cycle();
         end
      end
      check_eq("R7", "filler never orphan", 96'(orphan_err), 96'd0);
   endtask

   task automatic t_early_tail();
      logic [95:0] p;
      p = mk(24'h010203, 24'h040506, 24'h070809, 24'h0A0B0C);
      send_rec(p, 1, 1, 0, "R8");
      send_byte(2'b01, 6'h01);
      for (int i = 0; i < 3; i++) send_byte(2'b00, 6'h22);
      send_byte(2'b10, 6'h33);
      check_eq("R8", "early tail pulses trunc", 96'(last_trunc), 96'd1);
      check_eq("R8", "early tail no rec_valid", 96'(last_valid), 96'd0);
      check_eq("R9", "data held after dropped record", rec_data, p);
      idle_cycle();
      check_eq("R8", "trunc one cycle", 96'(last_trunc), 96'd0);
      send_byte(2'b00, 6'h04);
      check_eq("R8", "packet closed after early tail", 96'(orphan_err), 96'd1);
      do_reset();
   endtask

   initial begin
      t_reset();
      t_single();
      t_multi();
      t_orphan();
      t_head_abort();
      t_filler();
      t_early_tail();
      idle_cycle();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule